// File: doc/BRIEF.md
# Turn-Restricted Mesh Route Computation

This unit decides the output port of a 2D mesh router for each packet. When the head flit of a packet is accepted, the unit compares the node's own coordinates with the destination coordinates carried by that head flit. It then registers a one-hot output port: East, West, North, South or Local. The registered port stays fixed while the body flits of the packet pass, and it is cleared when the tail flit is accepted.

A mode input picks one of two routing policies:

- **Strict dimension order.** The packet travels along X until the X coordinates match, then along Y. The route is fully determined by the source and destination, and four of the eight possible turns can never occur.
- **West-first partially adaptive routing.** Only two turns are forbidden. Any westward travel is taken before any other direction. When a packet has both an X hop and a Y hop left that are productive, a per-port congestion hint chooses between East and the Y direction.

A small state machine tracks the packet boundary. It has three states:

- `ST_IDLE`: no route is held.
- `ST_HOLD`: a multi-flit packet owns the route.
- `ST_LAST`: a single-flit packet shows its route for one cycle.

Its transitions are:

- `T_HEAD_MULTI`: IDLE or LAST to HOLD, when a head flit without a tail mark is accepted.
- `T_HEAD_SINGLE`: IDLE or LAST to LAST, when a head flit that is also a tail is accepted.
- `T_TAIL`: HOLD to IDLE, when a tail flit is accepted.
- `T_EXPIRE`: LAST to IDLE, when no head flit arrives.
- `T_STAY`: every other case.

Top module: `mesh_route_unit`

## Requirements
- R1: The port vector is one-hot, with bit0 Local, bit1 East, bit2 West, bit3 North and bit4 South. North means increasing Y. In dimension-order mode (`rt_mode`=0), a destination X greater than the node X selects East, and a smaller destination X selects West, whatever the Y values and the congestion hint are.
- R2: In dimension-order mode, when the X coordinates are equal, a larger destination Y selects North and a smaller destination Y selects South, whatever the hint is.
- R3: In either mode, equal X and equal Y select Local.
- R4: In west-first mode (`rt_mode`=1), a destination X smaller than the node X selects West, even when the hint marks West as congested.
- R5: In west-first mode, when exactly one of East, North or South is productive, that port is selected whatever the hint is.
- R6: In west-first mode, when East and one Y direction are both productive, the unit selects the one whose hint bit is 0. The hint uses the same bit positions as the port, and 1 means congested. When both hint bits are 0, or both are 1, East is selected.
- R7: The route and `route_vld` appear in the cycle after the head flit is accepted. They then hold unchanged while body flits, or further head flits, are accepted, until the tail flit is accepted.
- R8: When a tail flit is accepted while a route is held, the route becomes zero and `route_vld` goes low in the next cycle.
- R9: A flit marked both head and tail shows its route for exactly one cycle, after which the route clears unless a new head flit is accepted.
- R10: After reset, the route is zero and `route_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_vld | input | 1 | A flit is accepted this cycle |
| flit_head | input | 1 | The accepted flit starts a packet |
| flit_tail | input | 1 | The accepted flit ends a packet |
| rt_mode | input | 1 | 0 = dimension order, 1 = west-first |
| node_x | input | COORD_W | This router's X coordinate |
| node_y | input | COORD_W | This router's Y coordinate |
| dest_x | input | COORD_W | Destination X coordinate from the head flit |
| dest_y | input | COORD_W | Destination Y coordinate from the head flit |
| busy_hint | input | 5 | Per-port congestion hint, using the port bit positions |
| route_port | output | 5 | Registered one-hot output port |
| route_vld | output | 1 | A route is currently held |

## Verification
Dimension-order mode is tried with destinations that differ in both coordinates, only in Y, and in neither, with the hint driven in opposition. This shows whether X really takes precedence and whether the hint is really ignored. West-first mode is tried with a westward destination under a West-congested hint, with single productive directions, and with East plus North or South under all four hint combinations. This separates the forced-West rule, the hint choice and the tie toward X. The packet-framing tests change the coordinates and send stray head flits during body flits. They also send tail flits and single-flit packets, which show whether the route is held and then cleared in the correct cycle.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
    localparam int NPORT = 5;
    localparam int P_LOC = 0;
    localparam int P_E   = 1;
    localparam int P_W   = 2;
    localparam int P_N   = 3;
    localparam int P_S   = 4;

    typedef logic [NPORT-1:0] port_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_LAST = 2'd2
    } rt_state_e;
endpackage

// File: rtl/mesh_route_dor.sv
module mesh_route_dor
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    output port_vec_t          port
);
    always_comb begin
        port = '0;
        if (dx > cx)       port[P_E]   = 1'b1;
        else if (dx < cx)  port[P_W]   = 1'b1;
        else if (dy > cy)  port[P_N]   = 1'b1;
        else if (dy < cy)  port[P_S]   = 1'b1;
        else               port[P_LOC] = 1'b1;
    end
endmodule

// File: rtl/mesh_route_wf.sv
module mesh_route_wf
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  port_vec_t          busy,
    output port_vec_t          port
);
    logic go_e, go_n, go_s, go_y, y_busy, pick_y;

    always_comb begin
        go_e   = dx > cx;
        go_n   = dy > cy;
        go_s   = dy < cy;
        go_y   = go_n | go_s;
        y_busy = go_n ? busy[P_N] : busy[P_S];
        // Y wins only when it alone is free; otherwise prefer X.
        pick_y = go_y & (!go_e | (busy[P_E] & !y_busy));
        port   = '0;
        if (dx < cx)      port[P_W]   = 1'b1;
        else if (pick_y)  port[go_n ? P_N : P_S] = 1'b1;
        else if (go_e)    port[P_E]   = 1'b1;
        else              port[P_LOC] = 1'b1;
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flit_vld,
    input  logic               flit_head,
    input  logic               flit_tail,
    input  logic               rt_mode,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [NPORT-1:0]   busy_hint,
    output logic [NPORT-1:0]   route_port,
    output logic               route_vld
);
    port_vec_t dor_port, wf_port, calc_port;
    rt_state_e state_q, state_d;
    logic      head_acc, tail_acc;

    mesh_route_dor #(.COORD_W(COORD_W)) u_dor (
        .cx(node_x), .cy(node_y), .dx(dest_x), .dy(dest_y), .port(dor_port)
    );

    mesh_route_wf #(.COORD_W(COORD_W)) u_wf (
        .cx(node_x), .cy(node_y), .dx(dest_x), .dy(dest_y),
        .busy(busy_hint), .port(wf_port)
    );

    assign calc_port = rt_mode ? wf_port : dor_port;
    assign head_acc  = flit_vld & flit_head & (state_q != ST_HOLD);
    assign tail_acc  = flit_vld & flit_tail;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_LAST: begin
                if (head_acc)              state_d = tail_acc ? ST_LAST : ST_HOLD;
                else if (state_q == ST_LAST) state_d = ST_IDLE;
            end
            ST_HOLD: if (tail_acc)         state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_port <= '0;
        end else if (head_acc) begin
            route_port <= calc_port;
        end else if (state_d == ST_IDLE) begin
            route_port <= '0;
        end
    end

    assign route_vld = (state_q != ST_IDLE);

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        route_vld |-> $onehot(route_port));
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !route_vld |-> (route_port == '0));
    p_west_only_westward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_mode && wf_port[P_W]) |-> (dest_x < node_x));
    p_dor_y_after_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dor_port[P_N] || dor_port[P_S]) |-> (dest_x == node_x));
    p_hold_body_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !(flit_vld && flit_tail)) |=> $stable(route_port));
    p_tail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && flit_vld && flit_tail) |=> (!route_vld && route_port == '0));
endmodule

// File: tb/sim_mesh_route_unit.sv
module sim_mesh_route_unit;
    localparam int CW = 4;
    localparam logic [4:0] LOC = 5'b00001, E = 5'b00010, W = 5'b00100,
                           N = 5'b01000, S = 5'b10000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic flit_vld = 1'b0, flit_head = 1'b0, flit_tail = 1'b0, rt_mode = 1'b0;
    logic [CW-1:0] node_x = '0, node_y = '0, dest_x = '0, dest_y = '0;
    logic [4:0] busy_hint = '0;
    logic [4:0] route_port;
    logic route_vld;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    mesh_route_unit #(.COORD_W(CW)) u0 (
        .clk, .rst_n, .flit_vld, .flit_head, .flit_tail, .rt_mode,
        .node_x, .node_y, .dest_x, .dest_y, .busy_hint, .route_port, .route_vld
    );

    task automatic check(string req, logic [4:0] exp_p, logic exp_v);
        checks++;
        if (route_port !== exp_p || route_vld !== exp_v) begin
            errors++;
            $display("FAIL %s: port=%b vld=%b expected port=%b vld=%b",
                     req, route_port, route_vld, exp_p, exp_v);
        end
    endtask

    // drive one flit across a clock edge, leave inputs idle, sample after edge
    task automatic flit(bit hd, bit tl, bit md, int cx, int cy, int dx, int dy, logic [4:0] hint);
        @(negedge clk);
        flit_vld = 1'b1; flit_head = hd; flit_tail = tl; rt_mode = md;
        node_x = CW'(cx); node_y = CW'(cy); dest_x = CW'(dx); dest_y = CW'(dy);
        busy_hint = hint;
        @(negedge clk);
        flit_vld = 1'b0; flit_head = 1'b0; flit_tail = 1'b0;
    endtask

    // route a head, check it, then close the packet with a tail
    task automatic route_one(string req, bit md, int cx, int cy, int dx, int dy,
                             logic [4:0] hint, logic [4:0] exp_p);
        flit(1, 0, md, cx, cy, dx, dy, hint);
        check(req, exp_p, 1'b1);
        flit(0, 1, md, 0, 0, 0, 0, '0);
    endtask

    task automatic t_dor();
        route_one("R1 east over north", 0, 3, 3, 7, 9, E, E);
        route_one("R1 west over south", 0, 5, 5, 1, 0, W, W);
        route_one("R2 north", 0, 4, 2, 4, 8, N, N);
        route_one("R2 south", 0, 4, 9, 4, 1, S, S);
        route_one("R3 local dor", 0, 6, 6, 6, 6, '1, LOC);
    endtask

    task automatic t_wf();
        route_one("R4 west forced", 1, 8, 2, 2, 9, W, W);
        route_one("R5 only east", 1, 2, 5, 9, 5, E, E);
        route_one("R5 only south", 1, 5, 7, 5, 3, S, S);
        route_one("R3 local wf", 1, 1, 1, 1, 1, '0, LOC);
        route_one("R6 tie free", 1, 1, 1, 5, 5, '0, E);
        route_one("R6 tie busy", 1, 1, 9, 5, 2, E | S, E);
        route_one("R6 east busy", 1, 1, 1, 5, 5, E, N);
        route_one("R6 north busy", 1, 1, 1, 5, 5, N, E);
        route_one("R6 east busy south", 1, 1, 9, 5, 2, E, S);
    endtask

    task automatic t_packet();
        flit(1, 0, 0, 2, 2, 9, 2, '0);
        check("R7 head latched", E, 1'b1);
        flit(0, 0, 0, 9, 9, 0, 0, '0);
        check("R7 body holds", E, 1'b1);
        flit(1, 0, 1, 9, 9, 0, 0, '0);
        check("R7 stray head ignored", E, 1'b1);
        flit(0, 1, 0, 0, 0, 0, 0, '0);
        check("R8 tail clears", '0, 1'b0);
        @(negedge clk);
        check("R8 stays clear", '0, 1'b0);
    endtask

    task automatic t_single();
        flit(1, 1, 0, 3, 3, 3, 0, '0);
        check("R9 single shown", S, 1'b1);
        @(negedge clk);
        check("R9 single expired", '0, 1'b0);
        flit(1, 1, 0, 3, 3, 3, 0, '0);
        flit(1, 0, 0, 3, 3, 0, 3, '0);
        check("R9 back-to-back head", W, 1'b1);
        flit(0, 1, 0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", '0, 1'b0);
        t_dor();
        t_wf();
        t_packet();
        t_single();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule